// File: doc/BRIEF.md
# Equalizer Coefficient Load Sequencer

This block sits between a byte-wide host register port and the coefficient store of a three-stage biquad equalizer. The host writes and reads 8-bit registers by address. A few control registers gate access: a run bit starts and stops the filter, an access register holds separate write and read enables, and a status bit reports that initialization is complete. Four byte-lane registers carry coefficient data. Each 32-bit coefficient goes in as four byte writes, least significant lane first. Writing the top lane commits the assembled word to the next slot of a fixed 15-slot sequence. The sequence covers biquad 1 to 3, and within each biquad the order is b0, b1, a1, a2, b2.

New coefficients land in a shadow bank. The bank that the filter uses is updated only when the host sets the run bit after a complete, uninterrupted 15-coefficient load. An aborted or partial load therefore never disturbs the filter. The shadow bank can be read back one byte per read, in the same lane order, and the slot advances after the top lane is read. Both banks come out of reset as a pass-through filter: b0 = 1.0 in S1.30 format (0x40000000) and every other coefficient 0.

Top module: `eq_coef_loader`

## Requirements
- R1: After reset, every slot whose position within its biquad is b0 (slot mod 5 = 0) reads 0x40000000 on the filter port, all other slots read 0, host_rdata is 0x00, and the run bit and both enables read 0.
- R2: Address 0x00 bit 0 (init done) reads 0 while pwr_up is low, and it is forced to 0 the cycle after pwr_up falls. It becomes 1 once pwr_up has been high for INIT_CYCLES clock edges.
- R3: A lane write changes nothing unless init done = 1, the run bit (address 0x01 bit 0) = 0 and the write enable (address 0x02 bit 0) = 1.
- R4: Lane registers 0x04, 0x05, 0x06 and 0x07 carry coefficient bits [7:0], [15:8], [23:16] and [31:24]. Writes must arrive in lane order, and a write to any lane other than the expected one is ignored.
- R5: An accepted write to lane 0x07 stores the assembled word in the current slot and advances the slot. Slot 14 is followed by slot 0.
- R6: Slot n holds biquad n/5, coefficient n mod 5 in the order b0, b1, a1, a2, b2. flt_idx = n returns active slot n, and flt_idx of 15 returns 0.
- R7: Clearing the run bit from 1, or raising the write enable or the read enable (address 0x02 bit 1), returns the slot to 0 and the expected lane to 0x04, and abandons the load in progress.
- R8: Raising the run bit copies the shadow bank into the active bank in the same edge, but only after 15 consecutive commits since the last index reset. Otherwise the active bank is unchanged.
- R9: With the read enable = 1, the run bit = 0 and init done = 1, a read of lane k returns byte k of the shadow word in the current slot, and a read of 0x07 advances the slot. In any other state a lane read returns 0x00.
- R10: Address 0x01 reads back the run bit in bit 0. Address 0x02 reads back the write enable in bit 0 and the read enable in bit 1.
- R11: A full set of 15 coefficients takes exactly 60 accepted lane writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_up | input | 1 | Equalizer powered; starts the initialization timer |
| host_we | input | 1 | Host register write strobe |
| host_re | input | 1 | Host register read strobe |
| host_addr | input | ADDR_W | Register address |
| host_wdata | input | 8 | Write data byte |
| host_rdata | output | 8 | Read data, valid the cycle after host_re and held until the next read |
| flt_idx | input | SLOT_W | Slot selected by the filter datapath |
| flt_coef | output | 32 | Active coefficient at flt_idx (S1.30) |

## Verification
The assertions assume the host never raises host_we and host_re in the same cycle, and that register traffic to the control addresses follows the handshake timing above. They also rely on the bank changing only through a write, so they relate every change of the active bank to a preceding run-bit write. The stimulus drives one register operation at a time, each strobe one cycle wide and set up on the falling edge. Power and reset changes are made only between register operations.

// File: rtl/eq_coef_pkg.sv
package eq_coef_pkg;

  localparam int unsigned NUM_BIQUADS  = 3;
  localparam int unsigned COEFS_PER_BQ = 5;
  localparam int unsigned NUM_SLOTS    = NUM_BIQUADS * COEFS_PER_BQ;
  localparam int unsigned SLOT_W       = $clog2(NUM_SLOTS + 1);
  localparam int unsigned COEF_W       = 32;
  localparam int unsigned BYTE_W       = 8;
  localparam int unsigned LANES        = COEF_W / BYTE_W;
  localparam int unsigned LANE_W       = $clog2(LANES);
  localparam int unsigned ADDR_W       = 8;

  // Register map (lane addresses must stay contiguous and in lane order)
  localparam logic [ADDR_W-1:0] REG_STATUS    = 8'h00;
  localparam logic [ADDR_W-1:0] REG_RUN       = 8'h01;
  localparam logic [ADDR_W-1:0] REG_ACCESS    = 8'h02;
  localparam logic [ADDR_W-1:0] REG_LANE_BASE = 8'h04;

  // 1.0 in S1.30
  localparam logic [COEF_W-1:0] UNITY = 32'h4000_0000;

  typedef enum logic [2:0] {
    CK_B0 = 3'd0,
    CK_B1 = 3'd1,
    CK_A1 = 3'd2,
    CK_A2 = 3'd3,
    CK_B2 = 3'd4
  } coef_kind_e;

  function automatic logic [COEF_W-1:0] pass_through_value(input int unsigned slot);
    coef_kind_e kind;
    kind = coef_kind_e'(3'(slot % COEFS_PER_BQ));
    return (kind == CK_B0) ? UNITY : '0;
  endfunction

endpackage

// File: rtl/eq_host_regs.sv
module eq_host_regs
  import eq_coef_pkg::*;
#(
  parameter int unsigned AW          = ADDR_W,
  parameter int unsigned BW          = BYTE_W,
  parameter int unsigned CW          = COEF_W,
  parameter int unsigned NL          = LANES,
  parameter int unsigned INIT_CYCLES = 16,
  localparam int unsigned LW         = $clog2(NL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_up,
  input  logic          host_we,
  input  logic          host_re,
  input  logic [AW-1:0] host_addr,
  input  logic [1:0]    ctl_bits,
  input  logic [CW-1:0] rd_word,
  output logic          init_done,
  output logic          start_q,
  output logic          wr_ena_q,
  output logic          rd_ena_q,
  output logic [LW-1:0] lane_sel,
  output logic          lane_wr,
  output logic          lane_rd_last,
  output logic          idx_clear,
  output logic          start_rise,
  output logic [BW-1:0] host_rdata
);

  localparam int unsigned INIT_W = $clog2(INIT_CYCLES + 1);

  logic [INIT_W-1:0] init_cnt_q, init_cnt_d;
  logic              start_d, wr_ena_d, rd_ena_d;
  logic [BW-1:0]     rdata_d;
  logic [AW-1:0]     lane_off;
  logic              lane_hit;
  logic              acc_ok, wr_ok, rd_ok;
  logic              run_wr, acc_wr;
  logic [BW-1:0]     rd_byte;

  // Address decode
  assign lane_off = host_addr - AW'(REG_LANE_BASE);
  assign lane_hit = (host_addr >= AW'(REG_LANE_BASE)) && (lane_off < AW'(NL));
  assign lane_sel = lane_off[LW-1:0];
  assign run_wr   = host_we && (host_addr == AW'(REG_RUN));
  assign acc_wr   = host_we && (host_addr == AW'(REG_ACCESS));

  // Access gating
  assign init_done = (init_cnt_q == INIT_W'(INIT_CYCLES));
  assign acc_ok    = init_done && !start_q;
  assign wr_ok     = acc_ok && wr_ena_q;
  assign rd_ok     = acc_ok && rd_ena_q;

  assign lane_wr      = host_we && lane_hit && wr_ok;
  assign lane_rd_last = host_re && !host_we && lane_hit && rd_ok && (lane_sel == LW'(NL - 1));
  assign start_rise   = run_wr && ctl_bits[0] && !start_q;
  assign idx_clear    = (run_wr && !ctl_bits[0] && start_q) ||
                        (acc_wr && ((ctl_bits[0] && !wr_ena_q) || (ctl_bits[1] && !rd_ena_q)));

  assign rd_byte = rd_word[lane_sel*BW +: BW];

  // Initialization timer
  always_comb begin
    init_cnt_d = init_cnt_q;
    if (!pwr_up) begin
      init_cnt_d = '0;
    end else if (!init_done) begin
      init_cnt_d = init_cnt_q + INIT_W'(1);
    end
  end

  // Control register next state
  always_comb begin
    start_d  = start_q;
    wr_ena_d = wr_ena_q;
    rd_ena_d = rd_ena_q;
    if (run_wr) begin
      start_d = ctl_bits[0];
    end
    if (acc_wr) begin
      wr_ena_d = ctl_bits[0];
      rd_ena_d = ctl_bits[1];
    end
  end

  // Read data mux
  always_comb begin
    rdata_d = host_rdata;
    if (host_re) begin
      if (host_addr == AW'(REG_STATUS)) begin
        rdata_d = {{(BW-1){1'b0}}, init_done};
      end else if (host_addr == AW'(REG_RUN)) begin
        rdata_d = {{(BW-1){1'b0}}, start_q};
      end else if (host_addr == AW'(REG_ACCESS)) begin
        rdata_d = {{(BW-2){1'b0}}, rd_ena_q, wr_ena_q};
      end else if (lane_hit) begin
        rdata_d = rd_ok ? rd_byte : '0;
      end else begin
        rdata_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_cnt_q <= '0;
      start_q    <= 1'b0;
      wr_ena_q   <= 1'b0;
      rd_ena_q   <= 1'b0;
      host_rdata <= '0;
    end else begin
      init_cnt_q <= init_cnt_d;
      start_q    <= start_d;
      wr_ena_q   <= wr_ena_d;
      rd_ena_q   <= rd_ena_d;
      host_rdata <= rdata_d;
    end
  end

endmodule

// File: rtl/eq_slot_seq.sv
module eq_slot_seq
  import eq_coef_pkg::*;
#(
  parameter int unsigned NS = NUM_SLOTS,
  parameter int unsigned SW = SLOT_W,
  parameter int unsigned BW = BYTE_W,
  parameter int unsigned CW = COEF_W,
  parameter int unsigned NL = LANES,
  localparam int unsigned LW = $clog2(NL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lane_wr,
  input  logic [LW-1:0] lane_sel,
  input  logic [BW-1:0] lane_data,
  input  logic          rd_adv,
  input  logic          idx_clear,
  input  logic          start_rise,
  output logic [SW-1:0] slot_q,
  output logic [LW-1:0] bpos_q,
  output logic          commit,
  output logic [CW-1:0] commit_word,
  output logic          copy
);

  localparam int unsigned CNT_W = $clog2(NS + 1);
  localparam int unsigned ASM_W = CW - BW;

  logic [SW-1:0]    slot_d, slot_inc;
  logic [LW-1:0]    bpos_d;
  logic [ASM_W-1:0] asm_q, asm_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             accept, full;

  assign accept      = lane_wr && (lane_sel == bpos_q);
  assign commit      = accept && (bpos_q == LW'(NL - 1));
  assign commit_word = {lane_data, asm_q};
  assign full        = (cnt_q == CNT_W'(NS));
  assign copy        = start_rise && full;
  assign slot_inc    = (slot_q == SW'(NS - 1)) ? '0 : slot_q + SW'(1);

  always_comb begin
    slot_d = slot_q;
    bpos_d = bpos_q;
    asm_d  = asm_q;
    cnt_d  = cnt_q;
    if (idx_clear) begin
      slot_d = '0;
      bpos_d = '0;
      cnt_d  = '0;
    end else begin
      if (accept) begin
        bpos_d = commit ? '0 : bpos_q + LW'(1);
        for (int l = 0; l < int'(NL) - 1; l++) begin
          if (bpos_q == LW'(l)) begin
            asm_d[l*BW +: BW] = lane_data;
          end
        end
      end
      if (commit) begin
        slot_d = slot_inc;
        if (!full) begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end else if (rd_adv) begin
        slot_d = slot_inc;
        cnt_d  = '0;
      end
      if (copy) begin
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      bpos_q <= '0;
      asm_q  <= '0;
      cnt_q  <= '0;
    end else begin
      slot_q <= slot_d;
      bpos_q <= bpos_d;
      asm_q  <= asm_d;
      cnt_q  <= cnt_d;
    end
  end

endmodule

// File: rtl/eq_coef_banks.sv
module eq_coef_banks
  import eq_coef_pkg::*;
#(
  parameter int unsigned NS = NUM_SLOTS,
  parameter int unsigned SW = SLOT_W,
  parameter int unsigned CW = COEF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [SW-1:0]    commit_slot,
  input  logic [CW-1:0]    commit_word,
  input  logic             copy,
  input  logic [SW-1:0]    rd_slot,
  input  logic [SW-1:0]    flt_idx,
  output logic [CW-1:0]    rd_word,
  output logic [CW-1:0]    flt_coef,
  output logic [NS*CW-1:0] shadow_flat,
  output logic [NS*CW-1:0] active_flat
);

  for (genvar g = 0; g < int'(NS); g++) begin : g_slot
    localparam logic [CW-1:0] RST_VAL = CW'(pass_through_value(g));
    logic [CW-1:0] sh_q, sh_d, ac_q, ac_d;

    always_comb begin
      sh_d = sh_q;
      if (commit && (commit_slot == SW'(g))) begin
        sh_d = commit_word;
      end
    end

    always_comb begin
      ac_d = ac_q;
      if (copy) begin
        ac_d = sh_q;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q <= RST_VAL;
        ac_q <= RST_VAL;
      end else begin
        sh_q <= sh_d;
        ac_q <= ac_d;
      end
    end

    assign shadow_flat[g*CW +: CW] = sh_q;
    assign active_flat[g*CW +: CW] = ac_q;
  end

  always_comb begin
    rd_word  = '0;
    flt_coef = '0;
    for (int i = 0; i < int'(NS); i++) begin
      if (rd_slot == SW'(i)) begin
        rd_word = shadow_flat[i*CW +: CW];
      end
      if (flt_idx == SW'(i)) begin
        flt_coef = active_flat[i*CW +: CW];
      end
    end
  end

endmodule

// File: rtl/eq_coef_loader.sv
module eq_coef_loader
  import eq_coef_pkg::*;
#(
  parameter int unsigned INIT_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_up,
  input  logic              host_we,
  input  logic              host_re,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  input  logic [SLOT_W-1:0] flt_idx,
  output logic [COEF_W-1:0] flt_coef
);

  logic                        init_done, start_q, wr_ena_q, rd_ena_q;
  logic [LANE_W-1:0]           lane_sel, bpos_q;
  logic                        lane_wr, lane_rd_last, idx_clear, start_rise;
  logic [SLOT_W-1:0]           slot_q;
  logic                        commit, copy;
  logic [COEF_W-1:0]           commit_word, rd_word;
  logic [NUM_SLOTS*COEF_W-1:0] shadow_flat, active_flat;

  eq_host_regs #(
    .AW(ADDR_W), .BW(BYTE_W), .CW(COEF_W), .NL(LANES), .INIT_CYCLES(INIT_CYCLES)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_up       (pwr_up),
    .host_we      (host_we),
    .host_re      (host_re),
    .host_addr    (host_addr),
    .ctl_bits     (host_wdata[1:0]),
    .rd_word      (rd_word),
    .init_done    (init_done),
    .start_q      (start_q),
    .wr_ena_q     (wr_ena_q),
    .rd_ena_q     (rd_ena_q),
    .lane_sel     (lane_sel),
    .lane_wr      (lane_wr),
    .lane_rd_last (lane_rd_last),
    .idx_clear    (idx_clear),
    .start_rise   (start_rise),
    .host_rdata   (host_rdata)
  );

  eq_slot_seq #(
    .NS(NUM_SLOTS), .SW(SLOT_W), .BW(BYTE_W), .CW(COEF_W), .NL(LANES)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .lane_wr     (lane_wr),
    .lane_sel    (lane_sel),
    .lane_data   (host_wdata),
    .rd_adv      (lane_rd_last),
    .idx_clear   (idx_clear),
    .start_rise  (start_rise),
    .slot_q      (slot_q),
    .bpos_q      (bpos_q),
    .commit      (commit),
    .commit_word (commit_word),
    .copy        (copy)
  );

  eq_coef_banks #(
    .NS(NUM_SLOTS), .SW(SLOT_W), .CW(COEF_W)
  ) u_banks (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit      (commit),
    .commit_slot (slot_q),
    .commit_word (commit_word),
    .copy        (copy),
    .rd_slot     (slot_q),
    .flt_idx     (flt_idx),
    .rd_word     (rd_word),
    .flt_coef    (flt_coef),
    .shadow_flat (shadow_flat),
    .active_flat (active_flat)
  );

endmodule

// File: rtl/eq_coef_loader_chk.sv
module eq_coef_loader_chk
  import eq_coef_pkg::*;
#(
  parameter int unsigned NS = NUM_SLOTS,
  parameter int unsigned SW = SLOT_W,
  parameter int unsigned LW = LANE_W,
  parameter int unsigned CW = COEF_W,
  parameter int unsigned AW = ADDR_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwr_up,
  input logic             init_done,
  input logic             start_q,
  input logic             wr_ena_q,
  input logic [SW-1:0]    slot_q,
  input logic [LW-1:0]    bpos_q,
  input logic [NS*CW-1:0] shadow_flat,
  input logic [NS*CW-1:0] active_flat,
  input logic             host_we,
  input logic [AW-1:0]    host_addr,
  input logic             run_bit
);

  // R2: power loss drops the init status on the next edge
  a_r2_init_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_up |=> !init_done);

  // R5: slot index never leaves the 15-slot range
  a_r5_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q < SW'(NS));

  // R3: shadow bank frozen whenever lane writes are not permitted
  a_r3_shadow_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !(init_done && !start_q && wr_ena_q) |=> $stable(shadow_flat));

  // R8: active bank changes only right after a run-bit rising write
  a_r8_active_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active_flat) |->
      $past(host_we && (host_addr == AW'(REG_RUN)) && run_bit && !start_q));

  // R7: raising the write enable restarts slot and lane position
  a_r7_wr_rise_restart: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_ena_q) |-> (slot_q == '0) && (bpos_q == '0));

endmodule

bind eq_coef_loader eq_coef_loader_chk #(
  .NS(eq_coef_pkg::NUM_SLOTS), .SW(eq_coef_pkg::SLOT_W), .LW(eq_coef_pkg::LANE_W),
  .CW(eq_coef_pkg::COEF_W), .AW(eq_coef_pkg::ADDR_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pwr_up      (pwr_up),
  .init_done   (init_done),
  .start_q     (start_q),
  .wr_ena_q    (wr_ena_q),
  .slot_q      (slot_q),
  .bpos_q      (bpos_q),
  .shadow_flat (shadow_flat),
  .active_flat (active_flat),
  .host_we     (host_we),
  .host_addr   (host_addr),
  .run_bit     (host_wdata[0])
);

// File: tb/eq_coef_loader_tb.sv
module eq_coef_loader_tb;
  import eq_coef_pkg::*;

  localparam int INIT_CYC = 16;

  logic              clk, rst_n, pwr_up, host_we, host_re;
  logic [ADDR_W-1:0] host_addr;
  logic [BYTE_W-1:0] host_wdata, host_rdata;
  logic [SLOT_W-1:0] flt_idx;
  logic [COEF_W-1:0] flt_coef;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  eq_coef_loader #(.INIT_CYCLES(INIT_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_up(pwr_up), .host_we(host_we), .host_re(host_re),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .flt_idx(flt_idx), .flt_coef(flt_coef)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Vector: {rd, req[3:0], addr[7:0], data[7:0], exp[7:0]}; rd=1 checks host_rdata
  localparam int NV = 26;
  localparam logic [28:0] VEC [NV] = '{
    {1'b1, 4'd2,  8'h00, 8'h00, 8'h01},  // R2 init done
    {1'b1, 4'd10, 8'h01, 8'h00, 8'h00},  // R10 run bit clear
    {1'b0, 4'd7,  8'h02, 8'h01, 8'h00},  // wr enable rise
    {1'b1, 4'd10, 8'h02, 8'h00, 8'h01},  // R10 access readback
    {1'b0, 4'd4,  8'h05, 8'hAA, 8'h00},  // R4 out of order, ignored
    {1'b0, 4'd4,  8'h04, 8'h11, 8'h00},
    {1'b0, 4'd4,  8'h06, 8'hBB, 8'h00},  // R4 out of order, ignored
    {1'b0, 4'd4,  8'h05, 8'h22, 8'h00},
    {1'b0, 4'd4,  8'h06, 8'h33, 8'h00},
    {1'b0, 4'd5,  8'h07, 8'h44, 8'h00},  // R5 commit slot 0
    {1'b0, 4'd7,  8'h02, 8'h03, 8'h00},  // rd enable rise resets slot
    {1'b1, 4'd9,  8'h04, 8'h00, 8'h11},  // R9 lane bytes
    {1'b1, 4'd9,  8'h05, 8'h00, 8'h22},
    {1'b1, 4'd9,  8'h06, 8'h00, 8'h33},
    {1'b1, 4'd9,  8'h07, 8'h00, 8'h44},
    {1'b1, 4'd9,  8'h04, 8'h00, 8'h00},  // R9 advanced to slot 1
    {1'b0, 4'd7,  8'h02, 8'h00, 8'h00},
    {1'b0, 4'd7,  8'h02, 8'h02, 8'h00},  // rd rise: slot 0
    {1'b0, 4'd8,  8'h01, 8'h01, 8'h00},  // start, incomplete load
    {1'b1, 4'd9,  8'h04, 8'h00, 8'h00},  // R9 gated by run bit
    {1'b1, 4'd10, 8'h01, 8'h00, 8'h01},  // R10 run readback
    {1'b0, 4'd7,  8'h01, 8'h00, 8'h00},  // stop
    {1'b1, 4'd9,  8'h04, 8'h00, 8'h11},  // R9 slot 0 again
    {1'b0, 4'd9,  8'h02, 8'h00, 8'h00},
    {1'b1, 4'd9,  8'h04, 8'h00, 8'h00},  // R9 gated by read enable
    {1'b1, 4'd10, 8'h02, 8'h00, 8'h00}   // R10 access cleared
  };

  function automatic logic [31:0] coef(input int k);
    return {8'(8'h80 + k), 8'(8'h40 + k), 8'(8'h20 + k), 8'(8'h10 + k)};
  endfunction

  function automatic logic [31:0] reset_val(input int k);
    return (k % 5 == 0) ? 32'h4000_0000 : 32'h0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    host_re = 1'b1; host_addr = a;
    @(negedge clk);
    host_re = 1'b0;
    v = host_rdata;
  endtask

  task automatic wr_word(input logic [31:0] w);
    for (int l = 0; l < 4; l++) wr(8'(8'h04 + l), w[8*l +: 8]);
  endtask

  task automatic rd_word_chk(input string req, input logic [31:0] exp);
    logic [7:0] v;
    for (int l = 0; l < 4; l++) begin
      rd(8'(8'h04 + l), v);
      check(req, {24'h0, v}, {24'h0, exp[8*l +: 8]});
    end
  endtask

  task automatic flt_chk(input string req, input int idx, input logic [31:0] exp);
    flt_idx = SLOT_W'(idx);
    #1;
    check(req, flt_coef, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; pwr_up = 1'b0; host_we = 1'b0; host_re = 1'b0;
    host_addr = '0; host_wdata = '0; flt_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 rdata", {24'h0, host_rdata}, 32'h0);
    for (int k = 0; k < 15; k++) flt_chk("R1 pass-through", k, reset_val(k));

    // R2 status low before init completes
    pwr_up = 1'b1;
    rd(8'h00, v);
    check("R2 init pending", {24'h0, v}, 32'h0);
    repeat (INIT_CYC + 2) @(negedge clk);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      logic [28:0] e;
      e = VEC[i];
      if (e[28]) begin
        rd(e[23:16], v);
        n_chk++;
        if (v !== e[7:0]) begin
          n_fail++;
          $display("FAIL R%0d vec%0d actual=%h expected=%h", e[27:24], i, v, e[7:0]);
        end
      end else begin
        wr(e[23:16], e[15:8]);
      end
    end
    flt_chk("R8 incomplete keeps active", 0, 32'h4000_0000);

    // R11 / R6: full 60-byte load, then start copies
    wr(8'h02, 8'h01);
    for (int k = 0; k < 15; k++) wr_word(coef(k));
    flt_chk("R8 no copy before start", 0, 32'h4000_0000);
    wr(8'h01, 8'h01);
    for (int k = 0; k < 15; k++) flt_chk("R11 R6 slot order after copy", k, coef(k));
    flt_chk("R6 index 15 reads zero", 15, 32'h0);

    // R3: writes ignored while running and while write enable is off
    wr_word(32'hEEEE_EEEE);
    wr(8'h01, 8'h00);
    wr(8'h02, 8'h00);
    wr_word(32'hEEEE_EEEE);
    wr(8'h02, 8'h02);
    rd_word_chk("R3 gated writes", coef(0));

    // R5 wrap: 16 coefficients, the 16th lands in slot 0
    wr(8'h02, 8'h03);
    for (int k = 0; k < 15; k++) wr_word(~coef(k));
    wr_word(32'h5A5A_A5C3);
    wr(8'h02, 8'h02);
    wr(8'h02, 8'h00);
    wr(8'h02, 8'h02);
    rd_word_chk("R5 wrap slot 0", 32'h5A5A_A5C3);
    rd_word_chk("R5 slot 1", ~coef(1));
    wr(8'h01, 8'h01);
    flt_chk("R8 cleared count blocks copy", 1, coef(1));
    wr(8'h01, 8'h00);

    // R7: stopping the filter restarts lane position
    wr(8'h02, 8'h03);
    wr(8'h04, 8'h55);
    wr(8'h05, 8'h66);
    wr(8'h01, 8'h01);
    wr(8'h01, 8'h00);
    wr_word(32'h1234_5678);
    wr(8'h02, 8'h00);
    wr(8'h02, 8'h02);
    rd_word_chk("R7 index restart", 32'h1234_5678);

    // R2 / R3: power loss drops init and blocks lane writes
    pwr_up = 1'b0;
    repeat (2) @(negedge clk);
    rd(8'h00, v);
    check("R2 powered down", {24'h0, v}, 32'h0);
    wr(8'h02, 8'h00);
    wr(8'h02, 8'h01);
    wr_word(32'hEEEE_EEEE);
    pwr_up = 1'b1;
    repeat (INIT_CYC + 2) @(negedge clk);
    rd(8'h00, v);
    check("R2 init after power", {24'h0, v}, 32'h1);
    wr(8'h02, 8'h00);
    wr(8'h02, 8'h02);
    rd_word_chk("R3 blocked while uninitialised", 32'h1234_5678);

    // R1: reset mid-run restores pass-through
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check("R1 rdata after reset", {24'h0, host_rdata}, 32'h0);
    flt_chk("R1 b0 slot", 0, 32'h4000_0000);
    flt_chk("R1 b0 slot biquad 2", 5, 32'h4000_0000);
    flt_chk("R1 b1 slot", 1, 32'h0);
    rd(8'h01, v);
    check("R1 run bit", {24'h0, v}, 32'h0);
    rd(8'h02, v);
    check("R1 enables", {24'h0, v}, 32'h0);

    finish_run();
  end

endmodule